// File: doc/BRIEF.md
# Serial EEPROM Emulator with SPI Slave Port

This block makes a byte-wide memory array look like a small serial EEPROM on a mode-0 SPI bus. A bus master lowers chip select, shifts in a one-byte command, and, for data commands, an address of one, two or three bytes sent most significant byte first. Read commands stream array bytes out on MISO for as long as chip select stays low. Write commands store the incoming bytes into the array. The SPI pins are oversampled by the system clock through synchronizers, so the system clock must run at least eight times faster than SCK.

A status byte reports a busy flag, a write-enable latch, two protect bits and a protect-enable bit. Data writes and status writes need the write-enable latch. When chip select rises after such a write, the block holds busy for a fixed number of system clock cycles. At the end of that time, busy and the latch clear together. While busy, only the status read is honoured. With one-byte addressing, an option lets bit 3 of the data opcodes act as the ninth address bit, which gives a 512-byte array.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Command 0x06 sets the write-enable latch and command 0x04 clears it; the latch is seen as bit 1 of the status byte.
- R2: Command 0x05 returns the status byte repeatedly while chip select stays low: bit 0 busy, bit 1 write-enable latch, bits 2 and 3 protect bits, bit 7 protect enable, bits 4 to 6 always zero. Command 0x01 with one data byte loads bits 7, 3 and 2 from that byte, starting when chip select rises; the reset value is 0x00.
- R3: After 0x03 or 0x02, ADDR_BYTES address bytes follow, most significant first. With one address byte and the opcode option on, opcode bit 3 (0x0B / 0x0A) selects address bit 8.
- R4: A data read returns the byte at the address, then successive bytes, wrapping from the last array address to zero for as long as chip select is low.
- R5: Data-write bytes go to successive addresses whose in-page offset wraps inside the starting page (PAGE_BYTES), never entering the next page.
- R6: A data write or status write issued while the write-enable latch is clear changes neither the array nor the status byte, and does not start busy.
- R7: Busy rises when chip select rises after at least one complete data byte of an enabled write, or one complete status byte, and lasts BUSY_CYCLES clocks. Busy and the write-enable latch fall in the same cycle.
- R8: While busy, every command other than 0x05 is ignored; a data read then returns zeros.
- R9: MISO shifts out MSB first, changing after SCK falling edges. It is low whenever the block is not sending, including while chip select is high.
- R10: Any unrecognised opcode is ignored until chip select rises: MISO stays low and the status byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |

## Verification
Two events can land in the same clock: the busy timer expiring, which clears the write-enable latch, and the reload of the MISO shift register with a fresh status byte during a continuous status read. The bench provokes this after every page program by polling with a single chip-select-low frame that streams status bytes across the whole busy window. It judges every byte by requiring bits 0 and 1 to agree. The number of busy bytes must fit the programmed duration, and the final byte must read zero.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_IGNORE
    } phase_e;

    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STAT_GET  = 8'h05;
    localparam logic [7:0] CMD_STAT_PUT  = 8'h01;
    localparam logic [7:0] CMD_DATA_GET  = 8'h03;
    localparam logic [7:0] CMD_DATA_PUT  = 8'h02;

    // opcode bit used as the ninth address bit in single-byte address mode
    localparam logic [7:0] OPC_HIBIT_MASK = 8'h08;

endpackage

// File: rtl/eep_spi_sync.sv
module eep_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic sel_o,
    output logic desel_o,
    output logic mosi_o
);
    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   csn_p;
    logic [STAGES-1:0] mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            csn_p  <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck_i};
            csn_p  <= {csn_p[STAGES-1:0], csn_i};
            mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
        end
    end

    assign sck_rise_o = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall_o = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign sel_o      = ~csn_p[STAGES-1];
    assign desel_o    = csn_p[STAGES-1] & ~csn_p[STAGES];
    assign mosi_o     = mosi_p[STAGES-1];
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1)) && !start_i;
endmodule

// File: rtl/eep_byte_array.sv
module eep_byte_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells_q[raddr_i];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_BYTES  = 1,
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 300,
    parameter bit OPC_A8      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso
);
    localparam int  AW    = $clog2(MEM_BYTES);
    localparam int  PW    = $clog2(PAGE_BYTES);
    localparam int  ABW   = 8 * ADDR_BYTES;
    localparam int  FW    = (AW > ABW) ? AW : ABW;
    localparam bit  A8_EN = OPC_A8 && (ADDR_BYTES == 1);
    localparam logic [AW-1:0] OFS_MASK   = AW'(PAGE_BYTES - 1);
    localparam logic [1:0]    LAST_ABYTE = 2'(ADDR_BYTES - 1);

    typedef struct packed {
        phase_e          phase;
        logic [2:0]      bit_cnt;
        logic [6:0]      rx_sh;
        logic [1:0]      abyte_cnt;
        logic [ABW-1:0]  acc;
        logic            hi_bit;
        logic            is_read;
        logic [AW-1:0]   addr;
        logic [7:0]      tx_sh;
        logic            load_pend;
        logic            wel;
        logic [2:0]      prot;       // {enable, bp1, bp0}
        logic            wr_seen;
        logic            sr_pend_vld;
        logic [2:0]      sr_pend;
    } state_t;

    state_t st_q, st_d;

    logic           sck_rise, sck_fall, sel_w, desel_w, mosi_s;
    logic           busy_w, busy_done, busy_start;
    logic           mem_we;
    logic [7:0]     mem_rdata;
    logic [7:0]     rx_byte, op_core, stat_byte;
    logic [ABW-1:0] acc_n;
    logic [FW-1:0]  addr_full;

    eep_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (spi_sck),
        .csn_i     (spi_cs_n),
        .mosi_i    (spi_mosi),
        .sck_rise_o(sck_rise),
        .sck_fall_o(sck_fall),
        .sel_o     (sel_w),
        .desel_o   (desel_w),
        .mosi_o    (mosi_s)
    );

    eep_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(busy_start),
        .busy_o (busy_w),
        .done_o (busy_done)
    );

    eep_byte_array #(.DEPTH(MEM_BYTES), .AW(AW)) array_i (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(st_q.addr),
        .wdata_i(rx_byte),
        .raddr_i(st_q.addr),
        .rdata_o(mem_rdata)
    );

    always_comb begin
        st_d       = st_q;
        mem_we     = 1'b0;
        busy_start = 1'b0;
        rx_byte    = {st_q.rx_sh, mosi_s};
        op_core    = A8_EN ? (rx_byte & ~OPC_HIBIT_MASK) : rx_byte;
        stat_byte  = {st_q.prot[2], 3'b000, st_q.prot[1:0], st_q.wel, busy_w};
        acc_n      = (st_q.acc << 8) | ABW'(rx_byte);
        addr_full  = FW'(acc_n) | (FW'(st_q.hi_bit) << 8);

        if (!sel_w) begin
            st_d.phase       = PH_OPCODE;
            st_d.bit_cnt     = '0;
            st_d.tx_sh       = '0;
            st_d.load_pend   = 1'b0;
            st_d.wr_seen     = 1'b0;
            st_d.sr_pend_vld = 1'b0;
            st_d.abyte_cnt   = '0;
            if (desel_w) begin
                if (st_q.phase == PH_WDATA && st_q.wr_seen) begin
                    busy_start = 1'b1;
                end
                if (st_q.sr_pend_vld) begin
                    busy_start = 1'b1;
                    st_d.prot  = st_q.sr_pend;
                end
            end
        end else begin
            if (sck_fall) begin
                if (st_q.load_pend) begin
                    st_d.tx_sh     = (st_q.phase == PH_RSTAT) ? stat_byte : mem_rdata;
                    st_d.load_pend = 1'b0;
                end else begin
                    st_d.tx_sh = {st_q.tx_sh[6:0], 1'b0};
                end
            end
            if (sck_rise) begin
                st_d.rx_sh   = rx_byte[6:0];
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    unique case (st_q.phase)
                        PH_OPCODE: begin
                            st_d.phase     = PH_IGNORE;
                            st_d.acc       = '0;
                            st_d.abyte_cnt = '0;
                            st_d.hi_bit    = A8_EN & rx_byte[3];
                            if (busy_w) begin
                                if (rx_byte == CMD_STAT_GET) begin
                                    st_d.phase     = PH_RSTAT;
                                    st_d.load_pend = 1'b1;
                                end
                            end else if (rx_byte == CMD_LATCH_ON) begin
                                st_d.wel = 1'b1;
                            end else if (rx_byte == CMD_LATCH_OFF) begin
                                st_d.wel = 1'b0;
                            end else if (rx_byte == CMD_STAT_GET) begin
                                st_d.phase     = PH_RSTAT;
                                st_d.load_pend = 1'b1;
                            end else if (rx_byte == CMD_STAT_PUT) begin
                                if (st_q.wel) st_d.phase = PH_WSTAT;
                            end else if (op_core == CMD_DATA_GET) begin
                                st_d.phase   = PH_ADDR;
                                st_d.is_read = 1'b1;
                            end else if (op_core == CMD_DATA_PUT) begin
                                if (st_q.wel) begin
                                    st_d.phase   = PH_ADDR;
                                    st_d.is_read = 1'b0;
                                end
                            end
                        end
                        PH_ADDR: begin
                            st_d.acc       = acc_n;
                            st_d.abyte_cnt = st_q.abyte_cnt + 2'd1;
                            if (st_q.abyte_cnt == LAST_ABYTE) begin
                                st_d.addr      = addr_full[AW-1:0];
                                st_d.phase     = st_q.is_read ? PH_RDATA : PH_WDATA;
                                st_d.load_pend = st_q.is_read;
                            end
                        end
                        PH_RDATA: begin
                            st_d.addr      = st_q.addr + 1'b1;
                            st_d.load_pend = 1'b1;
                        end
                        PH_WDATA: begin
                            mem_we       = 1'b1;
                            st_d.wr_seen = 1'b1;
                            st_d.addr    = (st_q.addr & ~OFS_MASK) |
                                           ((st_q.addr + 1'b1) & OFS_MASK);
                        end
                        PH_RSTAT: begin
                            st_d.load_pend = 1'b1;
                        end
                        PH_WSTAT: begin
                            st_d.sr_pend     = {rx_byte[7], rx_byte[3:2]};
                            st_d.sr_pend_vld = 1'b1;
                            st_d.phase       = PH_IGNORE;
                        end
                        default: ;
                    endcase
                end
            end
        end

        if (busy_done) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spi_miso = st_q.tx_sh[7];

    if (PW < 1 || PW > AW) begin : g_bad_page
        $error("PAGE_BYTES must be at least 2 and no larger than MEM_BYTES");
    end
endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk #(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          desel,
    input logic          busy,
    input logic          wel,
    input logic          mem_we,
    input logic [AW-1:0] waddr,
    input logic          miso
);
    logic             have_q;
    logic [AW-PW-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            page_q <= '0;
        end else if (!sel) begin
            have_q <= 1'b0;
        end else if (mem_we) begin
            have_q <= 1'b1;
            page_q <= waddr[AW-1:PW];
        end
    end

    AST_WEL_FALLS_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R7
    AST_BUSY_ONLY_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(desel)); // R7
    AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel)); // R6
    AST_STORE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel); // R6
    AST_NO_STORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy); // R8
    AST_STORE_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && have_q) |-> (waddr[AW-1:PW] == page_q)); // R5
    AST_MISO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso); // R9
endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk #(.AW(AW), .PW(PW)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_w),
    .desel (desel_w),
    .busy  (busy_w),
    .wel   (st_q.wel),
    .mem_we(mem_we),
    .waddr (st_q.addr),
    .miso  (spi_miso)
);

// File: tb/spi_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_slave_tb_top;
    localparam int H     = 4;
    localparam int MEM   = 512;
    localparam int PAGE  = 16;
    localparam int NPAGE = MEM / PAGE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [MEM];

    always #2.5 clk = ~clk;

    spi_eeprom_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_sck (sck),
        .spi_cs_n(cs_n),
        .spi_mosi(mosi),
        .spi_miso(miso)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(H);
            rx[i] = miso;
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic desel();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, r);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel();
        xfer(8'h05, r);
        xfer(8'h00, s);
        desel();
    endtask

    // stream status bytes in one frame until busy is seen low
    task automatic poll(output int nbusy, output logic [7:0] last);
        logic [7:0] r;
        nbusy = 0;
        last  = 8'hFF;
        sel();
        xfer(8'h05, r);
        for (int k = 0; k < 20; k++) begin
            xfer(8'h00, r);
            last = r;
            chk(r[0] == r[1], "R7", "busy and latch agree in status", r, {6'd0, r[0], r[0]});
            if (!r[0]) break;
            nbusy++;
        end
        desel();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] b, r, d;
        int nb;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        chk(miso === 1'b0, "R9", "miso after reset", miso, 0);
        rdsr(b);
        chk(b == 8'h00, "R2", "status after reset", b, 8'h00);

        cmd1(8'h06);
        rdsr(b);
        chk(b == 8'h02, "R1", "status after latch on", b, 8'h02);
        cmd1(8'h04);
        rdsr(b);
        chk(b == 8'h00, "R1", "status after latch off", b, 8'h00);

        // page programming sweep: start at offset 3, 18 bytes wrap in page
        for (int p = 0; p < NPAGE; p++) begin
            cmd1(8'h06);
            sel();
            xfer(8'h02 | ((p >= NPAGE / 2) ? 8'h08 : 8'h00), r);
            xfer(8'((p * PAGE + 3) & 8'hFF), r);
            for (int k = 0; k < PAGE + 2; k++) begin
                d = 8'((k * 7 + p * 13 + 1) & 8'hFF);
                xfer(d, r);
                ref_mem[p * PAGE + ((3 + k) % PAGE)] = d;
            end
            desel();
            chk(miso === 1'b0, "R9", "miso idle between frames", miso, 0);
            poll(nb, b);
            chk(nb >= 1 && nb <= 8, "R7", "busy status byte count", nb, 4);
            chk(b == 8'h00, "R7", "status after program", b, 8'h00);
        end

        // full sequential read with wrap past the last address
        sel();
        xfer(8'h03, r);
        xfer(8'h00, r);
        for (int i = 0; i < MEM + 2; i++) begin
            xfer(8'h00, b);
            chk(b == ref_mem[i % MEM], "R4", "sequential read / R5 page wrap", b, ref_mem[i % MEM]);
        end
        desel();

        // upper half via opcode bit 3, crossing the top of the array
        sel();
        xfer(8'h0B, r);
        xfer(8'hFE, r);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, b);
            chk(b == ref_mem[(510 + i) % MEM], "R3", "ninth address bit read", b, ref_mem[(510 + i) % MEM]);
        end
        desel();

        // write without latch
        sel();
        xfer(8'h02, r);
        xfer(8'h05, r);
        xfer(~ref_mem[5], r);
        desel();
        rdsr(b);
        chk(b == 8'h00, "R6", "no busy after unlatched write", b, 8'h00);
        sel();
        xfer(8'h03, r);
        xfer(8'h05, r);
        xfer(8'h00, b);
        desel();
        chk(b == ref_mem[5], "R6", "array unchanged by unlatched write", b, ref_mem[5]);

        // commands other than status read are ignored while busy
        cmd1(8'h06);
        sel();
        xfer(8'h02, r);
        xfer(8'h20, r);
        xfer(8'hA5, r);
        desel();
        ref_mem[8'h20] = 8'hA5;
        sel();
        xfer(8'h03, r);
        xfer(8'h20, r);
        xfer(8'h00, b);
        desel();
        chk(b == 8'h00, "R8", "read ignored while busy", b, 8'h00);
        poll(nb, b);
        chk(b == 8'h00, "R8", "status after busy ends", b, 8'h00);
        sel();
        xfer(8'h03, r);
        xfer(8'h20, r);
        xfer(8'h00, b);
        desel();
        chk(b == 8'hA5, "R8", "programmed byte after busy", b, 8'hA5);

        // status write: only bits 7, 3, 2 are stored
        cmd1(8'h06);
        sel();
        xfer(8'h01, r);
        xfer(8'hFF, r);
        desel();
        poll(nb, b);
        chk(nb >= 1, "R2", "status write starts busy", nb, 1);
        chk(b == 8'h8C, "R2", "status after write of ff", b, 8'h8C);
        cmd1(8'h06);
        rdsr(b);
        chk(b == 8'h8E, "R1", "latch with protect bits", b, 8'h8E);
        cmd1(8'h04);
        sel();
        xfer(8'h01, r);
        xfer(8'h00, r);
        desel();
        rdsr(b);
        chk(b == 8'h8C, "R6", "unlatched status write ignored", b, 8'h8C);
        cmd1(8'h06);
        sel();
        xfer(8'h01, r);
        xfer(8'h00, r);
        desel();
        poll(nb, b);
        chk(b == 8'h00, "R2", "status cleared", b, 8'h00);

        // unknown opcode
        sel();
        xfer(8'h9F, r);
        xfer(8'h00, b);
        chk(b == 8'h00, "R10", "unknown opcode first byte", b, 8'h00);
        xfer(8'h00, b);
        chk(b == 8'h00, "R10", "unknown opcode second byte", b, 8'h00);
        desel();
        rdsr(b);
        chk(b == 8'h00, "R10", "status after unknown opcode", b, 8'h00);
        chk(miso === 1'b0, "R9", "miso idle at end", miso, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule